// File: doc/BRIEF.md
# Front-Panel Key Matrix Scanner with Calibration Jumper Decode

This block reads a grid of front-panel push switches that are wired as ten rows by five columns, with a diode at each crossing. It pulls one row low at a time. A column multiplexer outside the block returns one column line, picked by a 3-bit select code, on a single input. The block steps that code through the five columns. It waits a programmable number of settle cycles after each change of the code, then samples the input, where a low level means the switch is pressed. When every row has been visited, the complete 50-bit picture of the panel is published in one step. A one-cycle strobe marks each completed scan whose picture differs from the one before.

Right after reset, and before any row is driven, the block reads a three-position jumper through two spare multiplexer positions. The result is one of three operating modes: calibration allowed, calibration locked, or a diagnostic cycling mode. The mode stays frozen until the next reset, so moving the jumper while powered has no effect. The mode decoding and the published switch picture are the outputs that firmware or downstream logic consumes.

Top module: `keypad_matrix_scanner`

## Requirements
- R1: At most one bit of `row_n` is low at any time, and all the other bits are high.
- R2: While a row is low, `col_sel` takes the values 0, 1, 2, 3, 4 in that order, starting at 0. Each value is held for SETTLE_CYCLES+1 clock cycles (default 4), and the column input is sampled on the last of those cycles.
- R3: A low `col_n` sampled while row r is low and `col_sel` is c sets bit r*5+c of `sw_state` to 1 (switch closed). A high level sets that bit to 0 (switch open).
- R4: Between the last column of one row and the first column of the next, all rows are high for GAP_CYCLES cycles (at least one). A row never goes low in the cycle right after a different row was low.
- R5: Rows are visited in the order 0, 1, ..., 9 and the sequence then wraps to row 0. The first row after reset is row 0.
- R6: `sw_state` changes only at the end of a complete scan, when all 50 bits are replaced together.
- R7: `sw_changed` is high for exactly one cycle at the end of a scan whose result differs from the previous published result. The published result after reset is all zeros (all switches open). No strobe follows a scan with an identical result.
- R8: After reset, and with all rows high, `col_sel` is 5 (calibration-enable position) for SETTLE_CYCLES+1 cycles and then 6 (calibration-inhibit position) for SETTLE_CYCLES+1 cycles. Each position is sampled once. `cal_mode` reads 0 (pending) until both samples are taken.
- R9: The mode encoding is as follows. 1 (calibration allowed) is produced when the position-5 sample is low, whatever the position-6 sample is. 2 (calibration locked) is produced when only the position-6 sample is low. 3 (diagnostic cycling) is produced when neither sample is low.
- R10: Once `cal_mode` is non-zero it keeps its value until reset, and changes on the jumper lines are ignored.
- R11: While `rst_n` is low, all rows are high, `sw_state` is 0, `sw_changed` is 0 and `cal_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_n | input | 1 | Selected column line from the external multiplexer, low means closed |
| row_n | output | 10 | Active-low row drives, one-hot low |
| col_sel | output | 3 | Multiplexer select code: 0..4 columns, 5 enable jumper, 6 inhibit jumper |
| sw_state | output | 50 | Published switch picture, bit row*5+col, 1 = closed |
| sw_changed | output | 1 | One-cycle strobe when a finished scan differs from the last |
| cal_mode | output | 2 | 0 pending, 1 calibration allowed, 2 calibration locked, 3 diagnostic |

## Verification
The bench models the diode matrix and jumper behaviourally and applies patterns at the start of a scan. The patterns include the first and last matrix positions, the all-pressed panel, repeated identical pictures, and random sparse and dense pictures. A design that mapped bits wrongly or sampled before the settle window would publish a wrong picture. A design that compared against the wrong reference would strobe on an unchanged picture or miss a change. A monitor watches the row and select waveforms for overlapping rows, a missing all-high gap, out-of-order rows and select codes held for the wrong time. Each jumper position, including both bits low, is tried across a separate reset, and the jumper is then moved to show the mode staying frozen.

// File: rtl/kms_pkg.sv
package kms_pkg;

   typedef enum logic [1:0] {
      MODE_PENDING  = 2'd0,
      MODE_CAL_OK   = 2'd1,
      MODE_CAL_LOCK = 2'd2,
      MODE_DIAG     = 2'd3
   } kms_mode_e;

   typedef enum logic [1:0] {
      PH_JMP_EN  = 2'd0,
      PH_JMP_INH = 2'd1,
      PH_GAP     = 2'd2,
      PH_COL     = 2'd3
   } kms_phase_e;

   function automatic kms_mode_e kms_decode(input logic en_low, input logic inh_low);
      if (en_low)       return MODE_CAL_OK;
      else if (inh_low) return MODE_CAL_LOCK;
      else              return MODE_DIAG;
   endfunction

endpackage

// File: rtl/kms_scan_seq.sv
module kms_scan_seq
   import kms_pkg::*;
#(
   parameter int NUM_ROWS      = 10,
   parameter int NUM_COLS      = 5,
   parameter int SEL_W         = 3,
   parameter int SETTLE_CYCLES = 3,
   parameter int GAP_CYCLES    = 1,
   parameter int ROW_W         = 4
)(
   input  logic                clk,
   input  logic                rst_n,
   output logic [NUM_ROWS-1:0] row_n,
   output logic [SEL_W-1:0]    col_sel,
   output logic                en_take,
   output logic                inh_take,
   output logic                sample_en,
   output logic                scan_last,
   output logic [ROW_W-1:0]    row_idx,
   output logic [SEL_W-1:0]    col_idx
);

   localparam int MAXC     = (SETTLE_CYCLES > GAP_CYCLES) ? SETTLE_CYCLES : GAP_CYCLES;
   localparam int CNT_W    = (MAXC < 2) ? 1 : $clog2(MAXC + 1);
   localparam int EN_CODE  = NUM_COLS;
   localparam int INH_CODE = NUM_COLS + 1;
   localparam int ROW_LAST = NUM_ROWS - 1;
   localparam int COL_LAST = NUM_COLS - 1;

   kms_phase_e       phase;
   logic [CNT_W-1:0] cnt;
   logic [ROW_W-1:0] row_q;
   logic [SEL_W-1:0] col_q;
   logic             slot_end;
   logic             gap_end;
   logic             row_active;

   generate
      if (SETTLE_CYCLES == 0) begin : g_no_settle
         assign slot_end = 1'b1;
      end else begin : g_settle
         assign slot_end = (cnt == CNT_W'(SETTLE_CYCLES));
      end
   endgenerate

   assign gap_end = (cnt == CNT_W'(GAP_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_JMP_EN;
         cnt   <= '0;
         row_q <= '0;
         col_q <= '0;
      end else begin
         unique case (phase)
            PH_JMP_EN: begin
               if (slot_end) begin
                  phase <= PH_JMP_INH;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            PH_JMP_INH: begin
               if (slot_end) begin
                  phase <= PH_GAP;
                  cnt   <= '0;
                  row_q <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            PH_GAP: begin
               if (gap_end) begin
                  phase <= PH_COL;
                  cnt   <= '0;
                  col_q <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            PH_COL: begin
               if (slot_end) begin
                  cnt <= '0;
                  if (col_q == SEL_W'(COL_LAST)) begin
                     phase <= PH_GAP;
                     col_q <= '0;
                     row_q <= (row_q == ROW_W'(ROW_LAST)) ? '0 : row_q + ROW_W'(1);
                  end else begin
                     col_q <= col_q + SEL_W'(1);
                  end
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            default: phase <= PH_JMP_EN;
         endcase
      end
   end

   assign row_active = (phase == PH_COL);

   generate
      for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row_drv
         assign row_n[r] = !(row_active && (row_q == ROW_W'(r)));
      end
   endgenerate

   always_comb begin
      unique case (phase)
         PH_JMP_EN:  col_sel = SEL_W'(EN_CODE);
         PH_JMP_INH: col_sel = SEL_W'(INH_CODE);
         PH_COL:     col_sel = col_q;
         default:    col_sel = '0;
      endcase
   end

   assign en_take   = (phase == PH_JMP_EN)  && slot_end;
   assign inh_take  = (phase == PH_JMP_INH) && slot_end;
   assign sample_en = row_active && slot_end;
   assign scan_last = (row_q == ROW_W'(ROW_LAST)) && (col_q == SEL_W'(COL_LAST));
   assign row_idx   = row_q;
   assign col_idx   = col_q;

endmodule

// File: rtl/kms_jumper_dec.sv
module kms_jumper_dec
   import kms_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      col_n,
   input  logic      en_take,
   input  logic      inh_take,
   output kms_mode_e mode
);

   logic en_low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_low_q <= 1'b0;
         mode     <= MODE_PENDING;
      end else begin
         if (en_take && (mode == MODE_PENDING)) begin
            en_low_q <= ~col_n;
         end
         if (inh_take && (mode == MODE_PENDING)) begin
            mode <= kms_decode(en_low_q, ~col_n);
         end
      end
   end

endmodule

// File: rtl/kms_snapshot.sv
module kms_snapshot #(
   parameter int NUM_ROWS = 10,
   parameter int NUM_COLS = 5,
   parameter int SEL_W    = 3,
   parameter int ROW_W    = 4
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         col_n,
   input  logic                         sample_en,
   input  logic                         scan_last,
   input  logic [ROW_W-1:0]             row_idx,
   input  logic [SEL_W-1:0]             col_idx,
   output logic [NUM_ROWS*NUM_COLS-1:0] snap,
   output logic                         changed
);

   localparam int NBITS = NUM_ROWS * NUM_COLS;
   localparam int IDX_W = $clog2(NBITS);

   logic [NBITS-1:0] work_q;
   logic [NBITS-1:0] work_nx;
   logic [IDX_W-1:0] bit_idx;

   assign bit_idx = IDX_W'(row_idx) * IDX_W'(NUM_COLS) + IDX_W'(col_idx);

   always_comb begin
      work_nx          = work_q;
      work_nx[bit_idx] = ~col_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_q  <= '0;
         snap    <= '0;
         changed <= 1'b0;
      end else begin
         changed <= 1'b0;
         if (sample_en) begin
            work_q <= work_nx;
            if (scan_last) begin
               snap    <= work_nx;
               changed <= (work_nx != snap);
            end
         end
      end
   end

endmodule

// File: rtl/keypad_matrix_scanner.sv
module keypad_matrix_scanner
   import kms_pkg::*;
#(
   parameter int NUM_ROWS      = 10,
   parameter int NUM_COLS      = 5,
   parameter int SEL_W         = 3,
   parameter int SETTLE_CYCLES = 3,
   parameter int GAP_CYCLES    = 1
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         col_n,
   output logic [NUM_ROWS-1:0]          row_n,
   output logic [SEL_W-1:0]             col_sel,
   output logic [NUM_ROWS*NUM_COLS-1:0] sw_state,
   output logic                         sw_changed,
   output logic [1:0]                   cal_mode
);

   localparam int ROW_W = (NUM_ROWS < 2) ? 1 : $clog2(NUM_ROWS);

   generate
      if (NUM_COLS + 2 > (1 << SEL_W)) begin : g_bad_sel
         $error("select code too narrow for columns plus two jumper positions");
      end
      if (GAP_CYCLES < 1) begin : g_bad_gap
         $error("at least one all-high cycle is needed between rows");
      end
      if (NUM_ROWS < 1 || NUM_COLS < 1) begin : g_bad_dim
         $error("matrix needs at least one row and one column");
      end
      if (SETTLE_CYCLES < 0) begin : g_bad_settle
         $error("settle count cannot be negative");
      end
   endgenerate

   logic             en_take;
   logic             inh_take;
   logic             sample_en;
   logic             scan_last;
   logic [ROW_W-1:0] row_idx;
   logic [SEL_W-1:0] col_idx;
   kms_mode_e        mode;

   kms_scan_seq #(
      .NUM_ROWS      (NUM_ROWS),
      .NUM_COLS      (NUM_COLS),
      .SEL_W         (SEL_W),
      .SETTLE_CYCLES (SETTLE_CYCLES),
      .GAP_CYCLES    (GAP_CYCLES),
      .ROW_W         (ROW_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .row_n     (row_n),
      .col_sel   (col_sel),
      .en_take   (en_take),
      .inh_take  (inh_take),
      .sample_en (sample_en),
      .scan_last (scan_last),
      .row_idx   (row_idx),
      .col_idx   (col_idx)
   );

   kms_jumper_dec u_jmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .col_n    (col_n),
      .en_take  (en_take),
      .inh_take (inh_take),
      .mode     (mode)
   );

   kms_snapshot #(
      .NUM_ROWS (NUM_ROWS),
      .NUM_COLS (NUM_COLS),
      .SEL_W    (SEL_W),
      .ROW_W    (ROW_W)
   ) u_snap (
      .clk       (clk),
      .rst_n     (rst_n),
      .col_n     (col_n),
      .sample_en (sample_en),
      .scan_last (scan_last),
      .row_idx   (row_idx),
      .col_idx   (col_idx),
      .snap      (sw_state),
      .changed   (sw_changed)
   );

   assign cal_mode = mode;

endmodule

// File: rtl/keypad_matrix_scanner_props.sv
module keypad_matrix_scanner_props #(
   parameter int NUM_ROWS = 10,
   parameter int NUM_COLS = 5,
   parameter int SEL_W    = 3
)(
   input logic                         clk,
   input logic                         rst_n,
   input logic [NUM_ROWS-1:0]          row_n,
   input logic [SEL_W-1:0]             col_sel,
   input logic [NUM_ROWS*NUM_COLS-1:0] sw_state,
   input logic                         sw_changed,
   input logic [1:0]                   cal_mode
);

   localparam logic [NUM_ROWS-1:0] ALL_HIGH = '1;

   assert_one_row_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~row_n));

   assert_sel_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (row_n != ALL_HIGH) |-> (col_sel < SEL_W'(NUM_COLS)));

   assert_gap_between_rows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(row_n) != ALL_HIGH) && (row_n != ALL_HIGH)) |-> (row_n == $past(row_n)));

   assert_state_moves_with_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_state != $past(sw_state)) |-> sw_changed);

   assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sw_changed |=> !sw_changed);

   assert_no_rows_while_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_mode == 2'd0) |-> (row_n == ALL_HIGH));

   assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cal_mode) != 2'd0) |-> (cal_mode == $past(cal_mode)));

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_outputs_R11: assert ((row_n == ALL_HIGH) && (sw_state == '0) &&
                                           !sw_changed && (cal_mode == 2'd0));
      end
   end

endmodule

bind keypad_matrix_scanner keypad_matrix_scanner_props #(
   .NUM_ROWS (NUM_ROWS),
   .NUM_COLS (NUM_COLS),
   .SEL_W    (SEL_W)
) u_props (
   .clk        (clk),
   .rst_n      (rst_n),
   .row_n      (row_n),
   .col_sel    (col_sel),
   .sw_state   (sw_state),
   .sw_changed (sw_changed),
   .cal_mode   (cal_mode)
);

// File: tb/keypad_matrix_scanner_test.sv
module keypad_matrix_scanner_test;

   localparam int R = 10;
   localparam int C = 5;
   localparam int S = 3;
   localparam int G = 1;
   localparam int N = R * C;
   localparam int SCAN_LEN = R * (G + C * (S + 1));

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          col_n;
   logic [R-1:0]  row_n;
   logic [2:0]    col_sel;
   logic [N-1:0]  sw_state;
   logic          sw_changed;
   logic [1:0]    cal_mode;

   logic [N-1:0]  sw = '0;
   logic          jen_n = 1'b1;
   logic          jinh_n = 1'b1;

   int vectors = 0;
   int misses = 0;
   int strobes = 0;
   int viol_r1 = 0, viol_r2 = 0, viol_r4 = 0, viol_r5 = 0;
   logic [N-1:0] exp_snap = '0;

   always #10 clk = ~clk;

   keypad_matrix_scanner uut (
      .clk(clk), .rst_n(rst_n), .col_n(col_n), .row_n(row_n),
      .col_sel(col_sel), .sw_state(sw_state), .sw_changed(sw_changed),
      .cal_mode(cal_mode)
   );

   // diode matrix and jumper model
   always_comb begin
      col_n = 1'b1;
      if (col_sel == 3'd5) col_n = jen_n;
      else if (col_sel == 3'd6) col_n = jinh_n;
      else if (col_sel < 3'(C)) begin
         for (int r = 0; r < R; r++)
            if (!row_n[r] && sw[r*C + int'(col_sel)]) col_n = 1'b0;
      end
   end

   always @(posedge clk) if (rst_n && sw_changed) strobes++;

   function automatic int low_row(input logic [R-1:0] rn);
      int k = -1;
      for (int r = 0; r < R; r++) if (!rn[r]) k = r;
      return k;
   endfunction

   function automatic logic [1:0] exp_mode(input logic en_n, input logic inh_n);
      if (!en_n) return 2'd1;
      if (!inh_n) return 2'd2;
      return 2'd3;
   endfunction

   // waveform monitor: R1, R2, R4, R5
   logic [R-1:0] p_row = '1;
   logic [2:0]   p_sel = '0;
   int run = 0;
   int last_row = -1;
   always @(negedge clk) begin
      if (!rst_n) begin
         p_row = '1; last_row = -1; run = 0;
      end else begin
         int cur;
         int prv;
         cur = low_row(row_n);
         prv = low_row(p_row);
         if ($countones(~row_n) > 1) viol_r1++;
         if (cur >= 0 && prv >= 0 && cur != prv) viol_r4++;
         if (cur >= 0 && prv < 0) begin
            if (cur != (last_row + 1) % R) viol_r5++;
            if (col_sel != 3'd0) viol_r2++;
            last_row = cur;
            run = 1;
         end else if (cur >= 0 && cur == prv) begin
            if (col_sel == p_sel) run++;
            else begin
               if (run != S + 1 || col_sel != p_sel + 3'd1) viol_r2++;
               run = 1;
            end
         end
         p_row = row_n;
         p_sel = col_sel;
      end
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic en_n, input logic inh_n);
      @(negedge clk);
      rst_n = 1'b0;
      sw = '0;
      jen_n = en_n;
      jinh_n = inh_n;
      exp_snap = '0;
      repeat (3) @(negedge clk);
      check(row_n == '1 && sw_state == '0 && !sw_changed && cal_mode == 2'd0, "R11 reset state",
            {row_n, sw_state[3:0], sw_changed, cal_mode}, {10'h3ff, 4'h0, 1'b0, 2'd0});
      rst_n = 1'b1;
      @(negedge clk);
      check(col_sel == 3'd5 && row_n == '1, "R8 enable position first", col_sel, 3'd5);
      repeat (S) @(negedge clk);
      check(col_sel == 3'd6 && cal_mode == 2'd0, "R8 inhibit position then pending",
            {col_sel, cal_mode}, {3'd6, 2'd0});
      repeat (20) @(negedge clk);
      check(cal_mode == exp_mode(en_n, inh_n), "R9 mode decode", cal_mode, exp_mode(en_n, inh_n));
   endtask

   task automatic wait_scan_start();
      logic p;
      @(negedge clk);
      p = row_n[0];
      forever begin
         @(negedge clk);
         if (p && !row_n[0]) break;
         p = row_n[0];
      end
   endtask

   task automatic trial(input logic [N-1:0] pat, input string tag);
      int s0;
      int exp_n;
      wait_scan_start();
      sw = pat;
      s0 = strobes;
      exp_n = (pat != exp_snap) ? 1 : 0;
      repeat (SCAN_LEN / 2) @(negedge clk);
      check(sw_state == exp_snap, {"R6 held mid-scan ", tag}, sw_state, exp_snap);
      repeat (SCAN_LEN / 2 + 5) @(negedge clk);
      check(sw_state == pat, {"R3 picture ", tag}, sw_state, pat);
      check(strobes - s0 == exp_n, {"R7 strobe count ", tag}, strobes - s0, exp_n);
      exp_snap = pat;
   endtask

   function automatic logic [N-1:0] rnd_pat(input bit sparse);
      logic [N-1:0] v;
      v = N'({$urandom, $urandom});
      if (sparse) v = v & N'({$urandom, $urandom}) & N'({$urandom, $urandom});
      return v;
   endfunction

   task automatic check_monitor(input string where);
      check(viol_r1 == 0, {"R1 single row ", where}, viol_r1, 0);
      check(viol_r2 == 0, {"R2 select order/hold ", where}, viol_r2, 0);
      check(viol_r4 == 0, {"R4 gap between rows ", where}, viol_r4, 0);
      check(viol_r5 == 0, {"R5 row order ", where}, viol_r5, 0);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      misses++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd7351));
      // session 1: calibration allowed
      do_reset(1'b0, 1'b1);
      trial('0, "all open again");
      trial(N'(1), "first position only");
      trial(N'(1) << (N - 1), "last position only");
      trial('1, "all closed");
      trial('1, "repeat all closed");
      trial(N'(1) << 7, "row1 col2");
      for (int i = 0; i < 8; i++) trial(rnd_pat(1'b1), "random sparse");
      for (int i = 0; i < 8; i++) trial(rnd_pat(1'b0), "random dense");
      trial(exp_snap, "repeat random");
      check_monitor("session1");
      // R10: move jumper after power-up
      jen_n = 1'b1; jinh_n = 1'b0;
      trial(rnd_pat(1'b0), "after jumper move");
      check(cal_mode == 2'd1, "R10 mode frozen", cal_mode, 2'd1);
      // session 2: locked
      do_reset(1'b1, 1'b0);
      trial(rnd_pat(1'b1), "locked session");
      jen_n = 1'b0;
      trial(rnd_pat(1'b1), "locked session 2");
      check(cal_mode == 2'd2, "R10 mode frozen locked", cal_mode, 2'd2);
      // session 3: diagnostic
      do_reset(1'b1, 1'b1);
      trial(rnd_pat(1'b0), "diag session");
      jen_n = 1'b0; jinh_n = 1'b0;
      trial(rnd_pat(1'b0), "diag session 2");
      check(cal_mode == 2'd3, "R10 mode frozen diag", cal_mode, 2'd3);
      // session 4: both low counts as allowed
      do_reset(1'b0, 1'b0);
      trial(rnd_pat(1'b1), "both-low session");
      check_monitor("all sessions");
      finish_run();
   end

endmodule